// File: doc/BRIEF.md
# Receiver Idle Time-out Counter

This block watches a serial receiver for silence. After a character has arrived it counts bit-period ticks, and it raises a sticky time-out flag when the programmed interval passes with no further character. Each unit of the 8-bit programmed value is worth four bit periods. A prescaler divides the incoming tick by four, and a down-counter holds the remaining units.

The countdown does not run freely. A nonzero programmed value arms the block, but the block still waits for the first received character before it starts counting. Every later character reloads the count and clears the prescaler. A start command from software clears the flag and puts the block back into waiting for a first character. A programmed value of zero turns detection off.

Top module: `rx_idle_timeout`

## Requirements
- R1: While the programmed value is zero, a received character does not start a countdown and the flag never sets.
- R2: After reset or a start command, ticks have no effect until a character is received.
- R3: With programmed value N (nonzero), the flag sets on the clock edge that samples the 4*N-th tick counted after the reloading character, and not earlier.
- R4: Every received character reloads the count from the programmed value and clears the prescaler, so a full 4*N ticks are needed again.
- R5: The flag is sticky: received characters and further ticks do not clear it.
- R6: A start command clears the flag on the next edge and returns the block to waiting for a first character.
- R7: When a start command and a received character fall in the same cycle, the start command wins and the block waits for a new character.
- R8: When a received character coincides with the final tick of a countdown, the reload wins and the flag does not set.
- R9: Once the count reaches zero it stays there, and extra ticks neither wrap it nor disturb the flag.
- R10: A change to the programmed value takes effect only at the next reload, and the running countdown keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle pulse, once per bit period |
| charRcvd | input | 1 | One-cycle pulse when the receiver completes a character |
| toValue | input | 8 | Programmed time-out in units of four bit periods; 0 disables |
| startCmd | input | 1 | One-cycle command: clear the flag and wait for a first character |
| timeoutFlag | output | 1 | Sticky idle time-out status |

## Verification
Two functions can fall in the same cycle. A received character can arrive together with the tick that would end the countdown. A start command can also arrive together with a received character. The bench provokes both cases by driving the two pulses high in the same cycle at the exact tick count. It judges the outcome from the flag afterwards: the flag must stay clear at that point, and it must set only after a further full interval, or never if the start command won.

// File: rtl/idle_to_pkg.sv
package idle_to_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } idleState_t;

  typedef struct packed {
    logic reload;
    logic clearPre;
    logic step;
  } dpCtrl_t;
endpackage

// File: rtl/idle_to_dp.sv
module idle_to_dp
  import idle_to_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [VAL_W-1:0] loadVal,
  output logic             lastStep
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;
  localparam logic [VAL_W-1:0] CNT_ONE = VAL_W'(1);

  logic [VAL_W-1:0] cnt;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      pre <= '0;
    end else if (ctl.reload) begin
      cnt <= loadVal;
      pre <= '0;
    end else if (ctl.clearPre) begin
      pre <= '0;
    end else if (ctl.step) begin
      pre <= pre + 1'b1;
      if (pre == PRE_MAX && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign lastStep = (pre == PRE_MAX) && (cnt == CNT_ONE);

  // R4: a reload leaves the prescaler cleared
  p_reload_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reload |=> (pre == '0));
  // R9: an exhausted count never wraps
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !ctl.reload) |=> (cnt == '0));
endmodule

// File: rtl/idle_to_ctrl.sv
module idle_to_ctrl
  import idle_to_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             charRcvd,
  input  logic             startCmd,
  input  logic [VAL_W-1:0] toValue,
  input  logic             lastStep,
  output dpCtrl_t          ctl,
  output logic             timeoutFlag
);
  idleState_t state, stateNxt;
  logic expire;

  always_comb begin
    ctl.reload   = charRcvd && !startCmd;
    ctl.clearPre = startCmd;
    ctl.step     = (state == ST_RUN) && bitTick && !charRcvd && !startCmd;
  end

  assign expire = ctl.step && lastStep;

  always_comb begin
    stateNxt = state;
    if (startCmd)      stateNxt = ST_WAIT;
    else if (charRcvd) stateNxt = (toValue != '0) ? ST_RUN : ST_WAIT;
    else if (expire)   stateNxt = ST_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_WAIT;
      timeoutFlag <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startCmd)    timeoutFlag <= 1'b0;
      else if (expire) timeoutFlag <= 1'b1;
    end
  end

  // R3: the flag rises only out of an active countdown
  p_rise_from_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> ($past(state) == ST_RUN));
  // R5: the flag holds until a start command
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !startCmd) |=> timeoutFlag);
  // R6: a start command clears the flag and re-enters the wait
  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (!timeoutFlag && state == ST_WAIT));
  // R1: a zero value never starts a countdown
  p_zero_disables_r1: assert property (@(posedge clk) disable iff (!rstN)
    (charRcvd && toValue == '0) |=> (state != ST_RUN));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import idle_to_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             charRcvd,
  input  logic [VAL_W-1:0] toValue,
  input  logic             startCmd,
  output logic             timeoutFlag
);
  dpCtrl_t ctl;
  logic    lastStep;

  idle_to_ctrl #(.VAL_W(VAL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .charRcvd(charRcvd),
    .startCmd(startCmd), .toValue(toValue), .lastStep(lastStep),
    .ctl(ctl), .timeoutFlag(timeoutFlag)
  );

  idle_to_dp #(.VAL_W(VAL_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadVal(toValue), .lastStep(lastStep)
  );
endmodule

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, charRcvd = 1'b0, startCmd = 1'b0;
  logic [7:0] toValue = 8'd0;
  logic timeoutFlag;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_idle_timeout u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .charRcvd(charRcvd),
    .toValue(toValue), .startCmd(startCmd), .timeoutFlag(timeoutFlag)
  );

  task automatic check(input string req, input logic exp);
    nRun++;
    if (timeoutFlag !== exp) begin
      nFail++;
      $display("FAIL %s: timeoutFlag=%b expected %b", req, timeoutFlag, exp);
    end
  endtask

  // each pulse spans exactly one rising edge; sampling happens at the next falling edge
  task automatic pulse(input logic t, input logic c, input logic s);
    @(negedge clk);
    bitTick = t; charRcvd = c; startCmd = s;
    @(negedge clk);
    bitTick = 1'b0; charRcvd = 1'b0; startCmd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_zero;      // R1
    toValue = 8'd0;
    pulse(0, 1, 0); ticks(20); check("R1", 1'b0);
  endtask

  task automatic t_wait;      // R2
    toValue = 8'd2;
    pulse(0, 0, 1); ticks(20); check("R2", 1'b0);
  endtask

  task automatic t_duration;  // R3, R5, R9, R6
    toValue = 8'd3;
    pulse(0, 0, 1); pulse(0, 1, 0);
    ticks(11); check("R3 before", 1'b0);
    ticks(1);  check("R3 at 4N", 1'b1);
    pulse(0, 1, 0); check("R5 char", 1'b1);
    ticks(40); check("R9 extra ticks", 1'b1);
    pulse(0, 0, 1); check("R6 clear", 1'b0);
    ticks(30); check("R6 waits", 1'b0);
  endtask

  task automatic t_reload;    // R4
    toValue = 8'd2;
    pulse(0, 0, 1); pulse(0, 1, 0);
    ticks(6); pulse(0, 1, 0);
    ticks(7); check("R4 before", 1'b0);
    ticks(1); check("R4 at 4N", 1'b1);
  endtask

  task automatic t_coincide;  // R8
    toValue = 8'd1;
    pulse(0, 0, 1); pulse(0, 1, 0);
    ticks(3); pulse(1, 1, 0); check("R8 coincide", 1'b0);
    ticks(3); check("R8 before", 1'b0);
    ticks(1); check("R8 after reload", 1'b1);
  endtask

  task automatic t_start_vs_char; // R7
    toValue = 8'd1;
    pulse(0, 0, 1); pulse(0, 1, 1);
    ticks(10); check("R7 start wins", 1'b0);
  endtask

  task automatic t_value_change; // R10
    toValue = 8'd2;
    pulse(0, 0, 1); pulse(0, 1, 0);
    toValue = 8'd5;
    ticks(7); check("R10 old before", 1'b0);
    ticks(1); check("R10 old length", 1'b1);
    pulse(0, 0, 1); pulse(0, 1, 0);
    ticks(19); check("R10 new before", 1'b0);
    ticks(1);  check("R10 new length", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset", 1'b0);
    t_zero();
    t_wait();
    t_duration();
    t_reload();
    t_coincide();
    t_start_vs_char();
    t_value_change();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule